// File: doc/BRIEF.md
# Double-Buffered SPI Slave

This block is a serial peripheral interface slave for SPI mode 0 (clock idles low, data captured on the rising clock edge, driven after the falling edge), most significant bit first. One shift engine carries both directions at once: each full serial clock cycle takes one bit in from the controller data line and returns one bit on the peripheral data line. A frame is 8 bits, or 16 bits when the wide-mode input is high. The wide-mode input is changed only while chip select is inactive.

The local side sees two holding registers. A word written into the transmit holding register waits there while the current frame shifts. It moves into the shift engine when the engine is idle with no word loaded, or at the end of a frame. Each finished frame lands in the receive holding register and raises a full flag, which also serves as the interrupt or DMA request. Frames can therefore run back to back with no local action between them.

The serial clock, controller data and chip select pins are each passed through two flip-flops and then sampled by the system clock. The system clock must run at least four times faster than the serial clock. While chip select is inactive, the output enable is low so that a pad can float the line, and the data output is driven low.

Top module: `spi_dbuf_slave`

## Requirements
- R1: After reset, the receive-full flag, the request, the overrun and underrun flags and the output enable are 0, and the transmit-empty flag is 1.
- R2: With wide mode low, a frame is 8 rising clock edges. Controller data is captured MSB first on each rising edge. The received byte appears in bits 7:0 of the receive data with bits 15:8 at zero. The transmitted byte is bits 7:0 of the loaded word, MSB first, with each next bit presented after a falling edge.
- R3: With wide mode high, a frame is 16 rising edges and all 16 bits are exchanged MSB first in both directions.
- R4: While chip select is high, the output enable is 0, and clock and data activity neither produces a received word nor advances the bit position of the next frame.
- R5: A completed frame sets receive-full and the request, and places the word in the receive data output. A read strobe clears receive-full.
- R6: A word written while a frame shifts is loaded automatically at the end of that frame and sent in the next frame with no idle time between the frames. Transmit-empty is 1 whenever the holding register is free.
- R7: A frame that completes while receive-full is set, with no read in that cycle, overwrites the receive word and sets the sticky overrun flag.
- R8: A frame that starts with no word loaded sends all zeros and sets the sticky underrun flag.
- R9: Raising chip select in the middle of a frame discards the partial received word and the partly sent transmit word. The next frame starts at bit 0 and sends the next queued word.
- R10: A read strobe in the same cycle as a frame completion returns the older word, leaves receive-full set with the new word, and does not set overrun.
- R11: A pulse on the flag-clear input returns the overrun and underrun flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck_i | input | 1 | Serial clock from the controller |
| spi_mosi_i | input | 1 | Serial data from the controller |
| spi_cs_n_i | input | 1 | Chip select, active low |
| spi_miso_o | output | 1 | Serial data to the controller |
| spi_miso_oe_o | output | 1 | Output enable for the serial data pad |
| wide_mode_i | input | 1 | 1 = 16-bit frames, 0 = 8-bit frames |
| tx_wr_i | input | 1 | Write strobe for the transmit holding register |
| tx_data_i | input | 16 | Word to transmit |
| rx_rd_i | input | 1 | Read strobe for the receive holding register |
| rx_data_o | output | 16 | Last received word |
| rx_full_o | output | 1 | Receive holding register holds an unread word |
| tx_empty_o | output | 1 | Transmit holding register is free |
| req_o | output | 1 | Interrupt / DMA request (new word available) |
| overrun_o | output | 1 | Sticky: unread word overwritten |
| underrun_o | output | 1 | Sticky: frame started without data |
| flag_clr_i | input | 1 | Clears overrun and underrun |

## Verification
A read strobe can arrive in the same cycle as a frame completion. The design must then treat the strobe as consuming the old word and keep the new word pending, with no overrun. The bench provokes this by leaving one word unread, then raising the strobe a fixed number of system clocks after the last rising serial clock edge of the next frame. That count covers the two synchroniser stages and the shift-engine register. The bench judges the outcome by the full flag, the data word and the overrun flag. A transmit write that coincides with a reload from the holding register is also covered: randomly sized bursts queue each next word in mid-frame.

// File: rtl/spi_dbuf_pkg.sv
package spi_dbuf_pkg;
    localparam int unsigned WORD_W = 16;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned CNT_W  = $clog2(WORD_W);
    localparam int unsigned N_PINS = 3;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [CNT_W-1:0]  cnt_t;
endpackage

// File: rtl/spi_dbuf_sync.sv
module spi_dbuf_sync #(
    parameter int unsigned       NSIG    = spi_dbuf_pkg::N_PINS,
    parameter logic [NSIG-1:0]   RST_VAL = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSIG-1:0] async_i,
    output logic [NSIG-1:0] sync_o
);
    typedef struct packed {
        logic [NSIG-1:0] meta;
        logic [NSIG-1:0] stab;
    } sync_st_t;

    sync_st_t st_d, st_q;

    // each pin gets its own two-stage chain
    for (genvar g = 0; g < NSIG; g++) begin : g_chain
        always_comb begin
            st_d.meta[g] = async_i[g];
            st_d.stab[g] = st_q.meta[g];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.meta <= RST_VAL;
            st_q.stab <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.stab;
endmodule

// File: rtl/spi_dbuf_shifter.sv
module spi_dbuf_shifter
    import spi_dbuf_pkg::*;
#(
    parameter int unsigned DW   = WORD_W,
    parameter int unsigned NW   = BYTE_W,
    parameter int unsigned CW   = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sck_lvl,
    input  logic          mosi_lvl,
    input  logic          cs_act,
    input  logic          wide,
    input  logic          hold_valid,
    input  logic [DW-1:0] hold_word,
    output logic          hold_take,
    output logic          starve,
    output logic          done_o,
    output logic [DW-1:0] word_o,
    output logic          miso_bit,
    output logic [CW-1:0] bit_cnt_o
);
    localparam logic [DW-1:0] NARROW_MASK = {{(DW-NW){1'b0}}, {NW{1'b1}}};
    localparam logic [CW-1:0] LAST_WIDE   = CW'(DW - 1);
    localparam logic [CW-1:0] LAST_NARROW = CW'(NW - 1);

    typedef struct packed {
        logic [DW-1:0] tx_sr;
        logic [DW-1:0] rx_sr;
        logic [CW-1:0] cnt;
        logic          loaded;
        logic          sck_prev;
        logic          done;
        logic [DW-1:0] word;
    } shf_st_t;

    shf_st_t sh_d, sh_q;

    logic [DW-1:0] mask;
    logic [CW-1:0] last_idx;
    logic          rise, fall;
    logic          can_load;

    always_comb begin
        mask     = wide ? '1 : NARROW_MASK;
        last_idx = wide ? LAST_WIDE : LAST_NARROW;
        rise     = sck_lvl & ~sh_q.sck_prev;
        fall     = ~sck_lvl & sh_q.sck_prev;
        can_load = (sh_q.cnt == '0) && !sh_q.loaded && hold_valid;

        sh_d          = sh_q;
        sh_d.sck_prev = sck_lvl;
        sh_d.done     = 1'b0;
        hold_take     = 1'b0;
        starve        = 1'b0;

        if (!cs_act) begin
            // abort: drop partial words
            if (sh_q.cnt != '0) begin
                sh_d.tx_sr  = '0;
                sh_d.loaded = 1'b0;
            end
            sh_d.cnt   = '0;
            sh_d.rx_sr = '0;
            if (can_load) begin
                sh_d.tx_sr  = hold_word & mask;
                sh_d.loaded = 1'b1;
                hold_take   = 1'b1;
            end
        end else if (rise) begin
            if (sh_q.cnt == '0 && !sh_q.loaded) begin
                starve = 1'b1;
            end
            if (sh_q.cnt == last_idx) begin
                sh_d.done  = 1'b1;
                sh_d.word  = {sh_q.rx_sr[DW-2:0], mosi_lvl} & mask;
                sh_d.rx_sr = '0;
                sh_d.cnt   = '0;
                if (hold_valid) begin
                    sh_d.tx_sr  = hold_word & mask;
                    sh_d.loaded = 1'b1;
                    hold_take   = 1'b1;
                end else begin
                    sh_d.tx_sr  = '0;
                    sh_d.loaded = 1'b0;
                end
            end else begin
                sh_d.rx_sr = {sh_q.rx_sr[DW-2:0], mosi_lvl};
                sh_d.cnt   = sh_q.cnt + 1'b1;
            end
        end else if (fall) begin
            if (sh_q.cnt != '0) begin
                sh_d.tx_sr = sh_q.tx_sr << 1;
            end
        end else if (can_load) begin
            sh_d.tx_sr  = hold_word & mask;
            sh_d.loaded = 1'b1;
            hold_take   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign done_o    = sh_q.done;
    assign word_o    = sh_q.word;
    assign miso_bit  = sh_q.tx_sr[wide ? LAST_WIDE : LAST_NARROW];
    assign bit_cnt_o = sh_q.cnt;
endmodule

// File: rtl/spi_dbuf_hold.sv
module spi_dbuf_hold
    import spi_dbuf_pkg::*;
#(
    parameter int unsigned DW = WORD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [DW-1:0] wr_data,
    input  logic          take,
    output logic          tx_valid,
    output logic [DW-1:0] tx_word,
    input  logic          rd,
    input  logic          done,
    input  logic [DW-1:0] done_word,
    output logic          rx_full,
    output logic [DW-1:0] rx_word,
    input  logic          starve,
    input  logic          clr,
    output logic          ovr,
    output logic          udr
);
    typedef struct packed {
        logic [DW-1:0] tx_hold;
        logic          tx_valid;
        logic [DW-1:0] rx_hold;
        logic          rx_full;
        logic          ovr;
        logic          udr;
    } hold_st_t;

    hold_st_t hr_d, hr_q;

    always_comb begin
        hr_d = hr_q;
        if (take) hr_d.tx_valid = 1'b0;
        if (wr) begin
            hr_d.tx_hold  = wr_data;
            hr_d.tx_valid = 1'b1;
        end
        if (clr) begin
            hr_d.ovr = 1'b0;
            hr_d.udr = 1'b0;
        end
        if (rd) hr_d.rx_full = 1'b0;
        if (done) begin
            hr_d.rx_hold = done_word;
            hr_d.rx_full = 1'b1;
            if (hr_q.rx_full && !rd) hr_d.ovr = 1'b1;
        end
        if (starve) hr_d.udr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hr_q <= '0;
        end else begin
            hr_q <= hr_d;
        end
    end

    assign tx_valid = hr_q.tx_valid;
    assign tx_word  = hr_q.tx_hold;
    assign rx_full  = hr_q.rx_full;
    assign rx_word  = hr_q.rx_hold;
    assign ovr      = hr_q.ovr;
    assign udr      = hr_q.udr;
endmodule

// File: rtl/spi_dbuf_slave.sv
module spi_dbuf_slave
    import spi_dbuf_pkg::*;
#(
    parameter int unsigned DW = WORD_W,
    parameter int unsigned NW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          spi_sck_i,
    input  logic          spi_mosi_i,
    input  logic          spi_cs_n_i,
    output logic          spi_miso_o,
    output logic          spi_miso_oe_o,
    input  logic          wide_mode_i,
    input  logic          tx_wr_i,
    input  logic [DW-1:0] tx_data_i,
    input  logic          rx_rd_i,
    output logic [DW-1:0] rx_data_o,
    output logic          rx_full_o,
    output logic          tx_empty_o,
    output logic          req_o,
    output logic          overrun_o,
    output logic          underrun_o,
    input  logic          flag_clr_i
);
    localparam int unsigned CW = $clog2(DW);
    // pin order in the synchroniser: [2]=cs_n, [1]=mosi, [0]=sck
    localparam logic [2:0] PIN_RST = 3'b100;

    logic [2:0]    pins_sync;
    logic          cs_act;
    logic          hold_take, starve, frame_done, miso_bit, tx_valid;
    logic [DW-1:0] tx_word, done_word;
    logic [CW-1:0] bit_cnt;

    spi_dbuf_sync #(.NSIG(3), .RST_VAL(PIN_RST)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({spi_cs_n_i, spi_mosi_i, spi_sck_i}),
        .sync_o  (pins_sync)
    );

    assign cs_act = ~pins_sync[2];

    spi_dbuf_shifter #(.DW(DW), .NW(NW), .CW(CW)) u_shf (
        .clk        (clk),
        .rst_n      (rst_n),
        .sck_lvl    (pins_sync[0]),
        .mosi_lvl   (pins_sync[1]),
        .cs_act     (cs_act),
        .wide       (wide_mode_i),
        .hold_valid (tx_valid),
        .hold_word  (tx_word),
        .hold_take  (hold_take),
        .starve     (starve),
        .done_o     (frame_done),
        .word_o     (done_word),
        .miso_bit   (miso_bit),
        .bit_cnt_o  (bit_cnt)
    );

    spi_dbuf_hold #(.DW(DW)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (tx_wr_i),
        .wr_data   (tx_data_i),
        .take      (hold_take),
        .tx_valid  (tx_valid),
        .tx_word   (tx_word),
        .rd        (rx_rd_i),
        .done      (frame_done),
        .done_word (done_word),
        .rx_full   (rx_full_o),
        .rx_word   (rx_data_o),
        .starve    (starve),
        .clr       (flag_clr_i),
        .ovr       (overrun_o),
        .udr       (underrun_o)
    );

    assign spi_miso_oe_o = cs_act;
    assign spi_miso_o    = cs_act & miso_bit;
    assign tx_empty_o    = ~tx_valid;
    assign req_o         = rx_full_o;
endmodule

// File: rtl/spi_dbuf_checker.sv
module spi_dbuf_checker #(
    parameter int unsigned CW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_act,
    input logic          frame_done,
    input logic [CW-1:0] bit_cnt,
    input logic          rx_full,
    input logic          rx_rd,
    input logic          tx_wr,
    input logic          tx_empty,
    input logic          overrun
);
    assert_idle_cnt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> bit_cnt == '0);

    assert_done_needs_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> $past(cs_act));

    assert_overrun_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(rx_full));

    assert_full_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_full) |-> $past(rx_rd));

    assert_write_fills_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr |=> !tx_empty);

    assert_read_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && rx_rd) |=> (rx_full && !$rose(overrun)));
endmodule

bind spi_dbuf_slave spi_dbuf_checker #(.CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_act     (cs_act),
    .frame_done (frame_done),
    .bit_cnt    (bit_cnt),
    .rx_full    (rx_full_o),
    .rx_rd      (rx_rd_i),
    .tx_wr      (tx_wr_i),
    .tx_empty   (tx_empty_o),
    .overrun    (overrun_o)
);

// File: tb/spi_dbuf_slave_tb.sv
module spi_dbuf_slave_tb_top;
    localparam int H = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, mosi = 1'b0, cs_n = 1'b1;
    logic miso, miso_oe;
    logic wide = 1'b0;
    logic tx_wr = 1'b0, rx_rd = 1'b0, fclr = 1'b0;
    logic [15:0] tx_data = '0;
    logic [15:0] rx_data;
    logic rx_full, tx_empty, req, ovr, udr;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    spi_dbuf_slave dut_i (
        .clk(clk), .rst_n(rst_n), .spi_sck_i(sck), .spi_mosi_i(mosi),
        .spi_cs_n_i(cs_n), .spi_miso_o(miso), .spi_miso_oe_o(miso_oe),
        .wide_mode_i(wide), .tx_wr_i(tx_wr), .tx_data_i(tx_data),
        .rx_rd_i(rx_rd), .rx_data_o(rx_data), .rx_full_o(rx_full),
        .tx_empty_o(tx_empty), .req_o(req), .overrun_o(ovr),
        .underrun_o(udr), .flag_clr_i(fclr)
    );

    function automatic logic [15:0] fit(input logic [15:0] w, input logic wd);
        return wd ? w : {8'h00, w[7:0]};
    endfunction

    task automatic check(input string req_tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req_tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic put_tx(input logic [15:0] w);
        @(negedge clk); tx_wr = 1'b1; tx_data = w;
        @(negedge clk); tx_wr = 1'b0;
    endtask

    task automatic take_rx();
        @(negedge clk); rx_rd = 1'b1;
        @(negedge clk); rx_rd = 1'b0;
    endtask

    task automatic cs_on();
        @(negedge clk); cs_n = 1'b0; tick(H);
    endtask

    task automatic cs_off();
        @(negedge clk); cs_n = 1'b1; tick(H);
    endtask

    // one mode-0 frame; optional mid-frame write and end-of-frame read strobe
    task automatic xfer(input logic [15:0] mo, input int nb, input int wr_bit,
                        input logic [15:0] wr_word, input int rd_at,
                        output logic [15:0] mi);
        mi = '0;
        for (int i = 0; i < nb; i++) begin
            @(negedge clk); mosi = mo[nb-1-i];
            tick(H);
            mi[nb-1-i] = miso;
            sck = 1'b1;
            for (int k = 1; k <= H; k++) begin
                @(negedge clk);
                rx_rd = (i == nb-1) && (k == rd_at);
                tx_wr = (i == wr_bit) && (k == 1);
                tx_data = wr_word;
            end
            rx_rd = 1'b0; tx_wr = 1'b0;
            sck = 1'b0;
        end
        tick(H);
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog act=%h exp=%h", 16'h0, 16'h1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] mi;
        int unsigned seed;
        seed = $urandom(32'd9143);
        tick(4);
        rst_n = 1'b1;
        tick(2);
        // R1 reset state
        check("R1 rx_full", 16'(rx_full), 16'h0);
        check("R1 tx_empty", 16'(tx_empty), 16'h1);
        check("R1 req", 16'(req), 16'h0);
        check("R1 flags", {14'h0, ovr, udr}, 16'h0);
        check("R1 oe", 16'(miso_oe), 16'h0);

        // R4: activity while deselected is ignored
        put_tx(16'h00C3);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk); mosi = i[0]; sck = 1'b1; tick(H);
            check("R4 oe low", 16'(miso_oe), 16'h0);
            sck = 1'b0; tick(H);
        end
        check("R4 no rx", 16'(rx_full), 16'h0);
        cs_on();
        check("R4 oe high", 16'(miso_oe), 16'h1);
        // R2 narrow frame
        xfer(16'hFFA5, 8, -1, 16'h0, 0, mi);
        check("R2 miso byte", mi, 16'h00C3);
        check("R5 full", 16'(rx_full), 16'h1);
        check("R5 req", 16'(req), 16'h1);
        check("R2 rx byte", rx_data, 16'h00A5);
        take_rx();
        check("R5 read clears", 16'(rx_full), 16'h0);
        cs_off();

        // R3 wide frame
        @(negedge clk); wide = 1'b1;
        put_tx(16'hBEEF);
        cs_on();
        xfer(16'h1234, 16, -1, 16'h0, 0, mi);
        check("R3 miso word", mi, 16'hBEEF);
        check("R3 rx word", rx_data, 16'h1234);
        take_rx();
        cs_off();

        // R10: read strobe coinciding with completion
        @(negedge clk); wide = 1'b0;
        cs_on();
        xfer(16'h0011, 8, -1, 16'h0, 0, mi);
        check("R10 first full", 16'(rx_full), 16'h1);
        xfer(16'h0022, 8, -1, 16'h0, 3, mi);
        check("R10 still full", 16'(rx_full), 16'h1);
        check("R10 new word", rx_data, 16'h0022);
        check("R10 no overrun", 16'(ovr), 16'h0);
        // R7 overrun
        xfer(16'h0033, 8, -1, 16'h0, 0, mi);
        check("R7 overrun", 16'(ovr), 16'h1);
        check("R7 overwrite", rx_data, 16'h0033);
        take_rx();
        cs_off();
        // R11 clear
        @(negedge clk); fclr = 1'b1;
        @(negedge clk); fclr = 1'b0;
        check("R11 cleared", {14'h0, ovr, udr}, 16'h0);

        // R8 underrun: nothing queued
        cs_on();
        xfer(16'h005A, 8, -1, 16'h0, 0, mi);
        check("R8 zeros", mi, 16'h0000);
        check("R8 underrun", 16'(udr), 16'h1);
        take_rx();
        cs_off();
        @(negedge clk); fclr = 1'b1;
        @(negedge clk); fclr = 1'b0;

        // R9 abort mid-frame
        put_tx(16'h00AA);
        tick(4);
        put_tx(16'h0055);
        check("R6 held", 16'(tx_empty), 16'h0);
        cs_on();
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); mosi = 1'b1; tick(H);
            sck = 1'b1; tick(H);
            sck = 1'b0;
        end
        tick(H);
        cs_off();
        check("R9 no rx", 16'(rx_full), 16'h0);
        cs_on();
        xfer(16'h0096, 8, -1, 16'h0, 0, mi);
        check("R9 next word", mi, 16'h0055);
        check("R9 aligned rx", rx_data, 16'h0096);
        check("R9 empty", 16'(tx_empty), 16'h1);
        take_rx();
        cs_off();
        @(negedge clk); fclr = 1'b1;
        @(negedge clk); fclr = 1'b0;

        // R6 random back-to-back bursts
        for (int b = 0; b < 12; b++) begin
            logic [15:0] tw [4];
            logic [15:0] mw [4];
            int len;
            int nb;
            len = 1 + int'($urandom % 3);
            @(negedge clk); wide = $urandom % 2;
            nb = wide ? 16 : 8;
            for (int i = 0; i < 4; i++) begin
                tw[i] = 16'($urandom);
                mw[i] = 16'($urandom);
            end
            put_tx(tw[0]);
            tick(4);
            if (len > 1) put_tx(tw[1]);
            cs_on();
            for (int i = 0; i < len; i++) begin
                xfer(mw[i], nb, (i >= 1 && i + 1 < len) ? 2 : -1, tw[i+1], 0, mi);
                check("R6 miso", mi, fit(tw[i], wide));
                check("R5 full", 16'(rx_full), 16'h1);
                check(wide ? "R3 rx" : "R2 rx", rx_data, fit(mw[i], wide));
                take_rx();
            end
            cs_off();
            check("R6 drained", 16'(tx_empty), 16'h1);
            check("R6 clean flags", {14'h0, ovr, udr}, 16'h0);
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule